// File: doc/BRIEF.md
# Predicated Vector Writeback and Flag Unit

This block decides, for one lane of a four-component vector datapath, which components of a freshly computed result may be committed to the register file and what the lane's four condition flags become afterwards. Every component has a 2-bit write mode. The mode can make the write depend on that component's own flag, so short conditional sequences need no branch. A separate 2-bit flag-control input refreshes the flags from the sign and zero status of the result. A small family of flag-only opcodes folds or spreads the flags across components instead.

The result and the lane's current flags arrive with the instruction. One clock later the block presents four write enables and the next flag vector. The register file and the arithmetic that produced the result sit outside. Internally each instruction falls into one operation class: `CLS_COMMIT` (predicated result commit), `CLS_ALL_AND`, `CLS_ALL_OR`, `CLS_PAIR_AND`, `CLS_PAIR_OR` or `CLS_SPLAT`. The class is chosen only by the opcode, and the output register moves from one instruction to the next on every cycle in which `in_valid` is high.

Component numbering: component 0 is X, 1 is Y, 2 is Z and 3 is W. X occupies `result[CW-1:0]`, and flag bit i and write-enable bit i belong to component i.

Top module: `pwb_commit`

## Requirements
- R1: During and right after reset, `out_valid`, `wr_en` and `flags_out` are all zero.
- R2: For a commit-class instruction on an active lane, the write-mode field of component i is `wmask[7-2i:6-2i]`, so X uses bits 7:6. The value 00 sets `wr_en[i]` when `flags_in[i]` is 1, 01 sets it when `flags_in[i]` is 0, 10 never sets it, and 11 always sets it. The decision uses the flags presented with the instruction, not the updated ones.
- R3: For a commit-class instruction on an active lane, `fctl` sets every flag bit i as follows: 00 keeps `flags_in[i]`, 01 loads the sign bit (bit CW-1) of component i, 10 loads 1 when component i equals zero, and 11 loads sign OR zero.
- R4: Opcode 0x08 sets all four flags to the AND of the four incoming flags.
- R5: Opcode 0x09 sets all four flags to the OR of the four incoming flags.
- R6: Opcode 0x0A sets X and Y to X AND Y, and sets Z and W to Z AND W.
- R7: Opcode 0x0B sets X and Y to X OR Y, and sets Z and W to Z OR W.
- R8: Opcode 0x0C copies the incoming X flag into all four flags.
- R9: Opcodes 0x08 to 0x0C raise no write enable and ignore `wmask`, `fctl` and `result`. Every other opcode is commit-class.
- R10: When `lane_active` is 0, the instruction raises no write enable and `flags_out` equals `flags_in` unchanged.
- R11: Outputs follow an accepted instruction by exactly one clock: `out_valid` equals the previous cycle's `in_valid`. After a cycle with `in_valid` low, `wr_en` is zero and `flags_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| lane_active | input | 1 | Lane enabled by the thread mask |
| opcode | input | 8 | Instruction opcode |
| wmask | input | 8 | Four 2-bit write modes, X in bits 7:6 |
| fctl | input | 2 | Flag update select |
| result | input | 4*CW | Four result components, X lowest |
| flags_in | input | 4 | Lane flags before the instruction |
| out_valid | output | 1 | Registered copy of `in_valid` |
| wr_en | output | 4 | Per-component register write enables |
| flags_out | output | 4 | Lane flags after the instruction |

## Verification
The only state in the block is its output register, so any wrong decision is visible at `wr_en` or `flags_out` exactly one clock after the instruction that caused it. A misordered write-mode field, a swapped flag pair or a class decoded from the wrong opcode therefore shows at once on the matching component bit. A register that loses its hold behaviour shows as a changed `flags_out` on the cycle after an idle input.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int NCOMP = 4;

    typedef enum logic [2:0] {
        CLS_COMMIT,
        CLS_ALL_AND,
        CLS_ALL_OR,
        CLS_PAIR_AND,
        CLS_PAIR_OR,
        CLS_SPLAT
    } op_cls_e;

    typedef enum logic [1:0] {
        WM_IF_SET = 2'b00,
        WM_IF_CLR = 2'b01,
        WM_NEVER  = 2'b10,
        WM_ALWAYS = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        FC_KEEP      = 2'b00,
        FC_SIGN      = 2'b01,
        FC_ZERO      = 2'b10,
        FC_SIGN_ZERO = 2'b11
    } fctl_e;

    localparam logic [7:0] OP_ALL_AND  = 8'h08;
    localparam logic [7:0] OP_ALL_OR   = 8'h09;
    localparam logic [7:0] OP_PAIR_AND = 8'h0A;
    localparam logic [7:0] OP_PAIR_OR  = 8'h0B;
    localparam logic [7:0] OP_SPLAT    = 8'h0C;

    function automatic op_cls_e classify(input logic [7:0] op);
        op_cls_e c;
        case (op)
            OP_ALL_AND:  c = CLS_ALL_AND;
            OP_ALL_OR:   c = CLS_ALL_OR;
            OP_PAIR_AND: c = CLS_PAIR_AND;
            OP_PAIR_OR:  c = CLS_PAIR_OR;
            OP_SPLAT:    c = CLS_SPLAT;
            default:     c = CLS_COMMIT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwb_mode_gate.sv
module pwb_mode_gate
    import pwb_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       flag,
    output logic       we
);
    always_comb begin
        unique case (wmode_e'(mode))
            WM_IF_SET: we = flag;
            WM_IF_CLR: we = ~flag;
            WM_NEVER:  we = 1'b0;
            WM_ALWAYS: we = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwb_status_flag.sv
module pwb_status_flag
    import pwb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] comp,
    input  logic [1:0]    sel,
    input  logic          old_flag,
    output logic          new_flag
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = comp[CW-1];
    assign is_zero = (comp == '0);

    always_comb begin
        unique case (fctl_e'(sel))
            FC_KEEP:      new_flag = old_flag;
            FC_SIGN:      new_flag = is_neg;
            FC_ZERO:      new_flag = is_zero;
            FC_SIGN_ZERO: new_flag = is_neg | is_zero;
        endcase
    end
endmodule

// File: rtl/pwb_flag_reduce.sv
module pwb_flag_reduce
    import pwb_pkg::*;
(
    input  op_cls_e          cls,
    input  logic [NCOMP-1:0] flags_old,
    input  logic [NCOMP-1:0] flags_commit,
    output logic [NCOMP-1:0] flags_next
);
    logic xy_and, zw_and, xy_or, zw_or;

    assign xy_and = flags_old[0] & flags_old[1];
    assign zw_and = flags_old[2] & flags_old[3];
    assign xy_or  = flags_old[0] | flags_old[1];
    assign zw_or  = flags_old[2] | flags_old[3];

    always_comb begin
        unique case (cls)
            CLS_COMMIT:   flags_next = flags_commit;
            CLS_ALL_AND:  flags_next = {NCOMP{&flags_old}};
            CLS_ALL_OR:   flags_next = {NCOMP{|flags_old}};
            CLS_PAIR_AND: flags_next = {zw_and, zw_and, xy_and, xy_and};
            CLS_PAIR_OR:  flags_next = {zw_or, zw_or, xy_or, xy_or};
            CLS_SPLAT:    flags_next = {NCOMP{flags_old[0]}};
            default:      flags_next = flags_old;
        endcase
    end
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
    import pwb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              lane_active,
    input  logic [7:0]        opcode,
    input  logic [7:0]        wmask,
    input  logic [1:0]        fctl,
    input  logic [4*CW-1:0]   result,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [3:0]        wr_en,
    output logic [3:0]        flags_out
);
    localparam int MW = 2 * NCOMP;

    op_cls_e          cls;
    logic [NCOMP-1:0] gate_we;
    logic [NCOMP-1:0] status_flags;
    logic [NCOMP-1:0] flags_next;
    logic [NCOMP-1:0] we_next;

    assign cls = classify(opcode);

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        pwb_mode_gate u_gate (
            .mode (wmask[MW-1-2*i -: 2]),
            .flag (flags_in[i]),
            .we   (gate_we[i])
        );
        pwb_status_flag #(.CW(CW)) u_stat (
            .comp     (result[i*CW +: CW]),
            .sel      (fctl),
            .old_flag (flags_in[i]),
            .new_flag (status_flags[i])
        );
    end

    pwb_flag_reduce u_reduce (
        .cls          (cls),
        .flags_old    (flags_in),
        .flags_commit (status_flags),
        .flags_next   (flags_next)
    );

    always_comb begin
        we_next = '0;
        if (lane_active && cls == CLS_COMMIT) begin
            we_next = gate_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                wr_en     <= we_next;
                flags_out <= lane_active ? flags_next : flags_in;
            end else begin
                wr_en     <= '0;
            end
        end
    end
endmodule

// File: rtl/pwb_commit_chk.sv
module pwb_commit_chk #(
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            lane_active,
    input logic [7:0]      opcode,
    input logic [7:0]      wmask,
    input logic [3:0]      flags_in,
    input logic            out_valid,
    input logic [3:0]      wr_en,
    input logic [3:0]      flags_out
);
    logic is_red;
    assign is_red = (opcode >= 8'h08) && (opcode <= 8'h0C);

    a_r11_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && wr_en == 4'b0 && $stable(flags_out)));
    a_r10_inactive_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_active) |=> (wr_en == 4'b0 && flags_out == $past(flags_in)));
    a_r9_reduce_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_red) |=> (wr_en == 4'b0));
    a_r2_never_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wmask[7:6] == 2'b10) |=> !wr_en[0]);
    a_r2_always_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_active && !is_red && wmask[7:6] == 2'b11) |=> wr_en[0]);
    a_r8_splat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_active && opcode == 8'h0C) |=> (flags_out == {4{$past(flags_in[0])}}));
endmodule

bind pwb_commit pwb_commit_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .lane_active (lane_active),
    .opcode      (opcode),
    .wmask       (wmask),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .wr_en       (wr_en),
    .flags_out   (flags_out)
);

// File: tb/pwb_commit_tb.sv
module pwb_commit_tb;
    localparam int CW = 16;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            lane_active = 1'b0;
    logic [7:0]      opcode = '0;
    logic [7:0]      wmask = '0;
    logic [1:0]      fctl = '0;
    logic [4*CW-1:0] result = '0;
    logic [3:0]      flags_in = '0;
    logic            out_valid;
    logic [3:0]      wr_en;
    logic [3:0]      flags_out;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwb_commit #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_active(lane_active),
        .opcode(opcode), .wmask(wmask), .fctl(fctl), .result(result),
        .flags_in(flags_in), .out_valid(out_valid), .wr_en(wr_en), .flags_out(flags_out)
    );

    function automatic logic is_red(input logic [7:0] op);
        return (op >= 8'h08) && (op <= 8'h0C);
    endfunction

    function automatic logic [3:0] exp_we(input logic act, input logic [7:0] op,
                                          input logic [7:0] wm, input logic [3:0] f);
        logic [3:0] e = '0;
        if (act && !is_red(op)) begin
            for (int i = 0; i < 4; i++) begin
                case (wm[7-2*i -: 2])
                    2'b00: e[i] = f[i];
                    2'b01: e[i] = !f[i];
                    2'b10: e[i] = 1'b0;
                    default: e[i] = 1'b1;
                endcase
            end
        end
        return e;
    endfunction

    function automatic logic [3:0] exp_flags(input logic act, input logic [7:0] op,
                                             input logic [1:0] fc, input logic [4*CW-1:0] r,
                                             input logic [3:0] f);
        logic [3:0] e = f;
        if (!act) return f;
        case (op)
            8'h08: e = (f == 4'hF) ? 4'hF : 4'h0;
            8'h09: e = (f != 4'h0) ? 4'hF : 4'h0;
            8'h0A: e = {{2{f[2] & f[3]}}, {2{f[0] & f[1]}}};
            8'h0B: e = {{2{f[2] | f[3]}}, {2{f[0] | f[1]}}};
            8'h0C: e = f[0] ? 4'hF : 4'h0;
            default: begin
                for (int i = 0; i < 4; i++) begin
                    logic [CW-1:0] c = r[i*CW +: CW];
                    logic s = c[CW-1];
                    logic z = (c == 0);
                    case (fc)
                        2'b00: e[i] = f[i];
                        2'b01: e[i] = s;
                        2'b10: e[i] = z;
                        default: e[i] = s | z;
                    endcase
                end
            end
        endcase
        return e;
    endfunction

    task automatic check(input string req, input logic [3:0] got_we, input logic [3:0] want_we,
                         input logic [3:0] got_f, input logic [3:0] want_f,
                         input logic got_v, input logic want_v);
        n_run++;
        if (got_we !== want_we || got_f !== want_f || got_v !== want_v) begin
            n_fail++;
            $display("FAIL %s: we=%b f=%b v=%b expected we=%b f=%b v=%b",
                     req, got_we, got_f, got_v, want_we, want_f, want_v);
        end
    endtask

    task automatic apply(input string req, input logic act, input logic [7:0] op,
                         input logic [7:0] wm, input logic [1:0] fc,
                         input logic [4*CW-1:0] r, input logic [3:0] f);
        in_valid = 1'b1; lane_active = act; opcode = op; wmask = wm; fctl = fc;
        result = r; flags_in = f;
        @(negedge clk);
        check(req, wr_en, exp_we(act, op, wm, f), flags_out,
              exp_flags(act, op, fc, r, f), out_valid, 1'b1);
    endtask

    function automatic logic [CW-1:0] pat(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'h7FFF;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", wr_en, 4'b0, flags_out, 4'b0, out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", wr_en, 4'b0, flags_out, 4'b0, out_valid, 1'b0);

        // R2: every write mask against every flag vector, flags held
        for (int wm = 0; wm < 256; wm++)
            for (int f = 0; f < 16; f++)
                apply("R2", 1'b1, (wm[0] ? 8'h10 : 8'h0D), 8'(wm), 2'b00,
                      {16'h1234, 16'h0, 16'h8001, 16'h0007}, 4'(f));

        // R3: flag control over sign/zero patterns, write-modes using old flags (R2)
        for (int fc = 0; fc < 4; fc++)
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++)
                    for (int c = 0; c < 5; c++)
                        for (int d = 0; d < 5; d++)
                            apply("R3", 1'b1, 8'h21, 8'h00, 2'(fc),
                                  {pat(d), pat(c), pat(b), pat(a)}, 4'(a + 3 * c));

        // R4..R8 with R9: reduction opcodes ignore wmask, fctl and result
        for (int op = 8; op <= 12; op++)
            for (int f = 0; f < 16; f++)
                for (int fc = 0; fc < 4; fc++)
                    apply(op == 8 ? "R4" : op == 9 ? "R5" : op == 10 ? "R6" :
                          op == 11 ? "R7" : "R8/R9",
                          1'b1, 8'(op), 8'hFF, 2'(fc), {4{16'h8000}}, 4'(f));

        // R10: inactive lane, all classes
        for (int op = 7; op <= 13; op++)
            for (int f = 0; f < 16; f++)
                apply("R10", 1'b0, 8'(op), 8'hFF, 2'b11, {4{16'h0000}}, 4'(f));

        // R11: idle cycle clears enables and holds flags
        apply("R11", 1'b1, 8'h10, 8'hFF, 2'b00, '0, 4'b1010);
        held = flags_out;
        in_valid = 1'b0; flags_in = 4'b0101; wmask = 8'hFF; lane_active = 1'b1;
        @(negedge clk);
        check("R11", wr_en, 4'b0, flags_out, held, out_valid, 1'b0);
        @(negedge clk);
        check("R11", wr_en, 4'b0, flags_out, held, out_valid, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule